// File: doc/BRIEF.md
# Conditioned-Operand Adder ALU

This block is a small arithmetic unit. All of its results come from one N-bit adder (8 bits by default). Each operand first passes through its own conditioning stage, which can clear the operand, invert it, or pass it through unchanged. The adder's carry-in is a separate control bit. Combining these five control bits gives addition, subtraction in either direction, negation or ones' complement of either operand, increment, pass-through and a constant zero. No separate subtractor or negator exists.

The result and four flags are registered, so an operation issued on one clock edge appears on the outputs after that edge. The flags are carry-out, zero, negative and signed overflow. A parameter chooses how the adder forms its carries: a ripple chain, or a logarithmic-depth parallel-prefix network. Both produce the same results.

Top module: `cond_adder_alu`

## Requirements
- R1: A high `rst_i` sampled on a clock edge sets `sum_o` to 0, `zf_o` to 1 and `co_o`, `nf_o`, `vf_o` to 0 after that edge.
- R2: The outputs present after a clock edge are a function of the `a_i`, `b_i` and `ctl_i` values sampled on that edge only (one register stage of latency).
- R3: `ctl_i` bit 4 clears operand A, bit 3 inverts A, bit 2 clears B, bit 1 inverts B, bit 0 is the adder carry-in. Clearing is applied before inversion, so clear plus invert yields all ones.
- R4: `sum_o` equals (X + Y + carry-in) mod 2^N, where X and Y are the conditioned operands. `co_o` is bit N of that sum.
- R5: With `ctl_i` = 5'b00011, `sum_o` = A − B mod 2^N, and `co_o` is 1 exactly when A ≥ B unsigned.
- R6: `ctl_i` = 5'b01101 gives −A, 5'b01100 gives ~A, 5'b10011 gives −B and 5'b10010 gives ~B.
- R7: `zf_o` is 1 exactly when all bits of `sum_o` are 0.
- R8: `nf_o` equals the most significant bit of `sum_o`.
- R9: `vf_o` is 1 exactly when X and Y have equal sign bits and the sign bit of `sum_o` differs from them.
- R10: The ripple variant (`PREFIX_CARRY` = 0) and the prefix variant (`PREFIX_CARRY` = 1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctl_i | input | 5 | {clear A, invert A, clear B, invert B, carry-in} |
| sum_o | output | WIDTH | Registered adder result |
| co_o | output | 1 | Registered carry-out |
| zf_o | output | 1 | Registered zero flag |
| nf_o | output | 1 | Registered negative flag |
| vf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench builds the block twice at WIDTH = 4: once with the prefix carry network and once with the ripple chain. Both copies receive the same stimulus. At this width, every pairing of the two operands with all 32 control words fits in a few thousand cycles. The sweep therefore reaches every conditioning combination, every carry and overflow boundary, and every wrap of subtraction and negation. It also compares the two carry structures bit for bit.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic clr_a;
    logic inv_a;
    logic clr_b;
    logic inv_b;
    logic cin;
  } ctl_t;
endpackage

// File: rtl/operand_shaper.sv
module operand_shaper #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         clr_i,
  input  logic         inv_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] masked;

  // clear first, then optional inversion
  assign masked = clr_i ? '0 : d_i;
  assign q_o    = masked ^ {W{inv_i}};
endmodule

// File: rtl/carry_core.sv
module carry_core #(
  parameter int W            = 8,
  parameter bit PREFIX_CARRY = 1'b1
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] s_o,
  output logic         cout_o
);
  localparam int LVL = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] gen0;
  logic [W-1:0] prop0;
  logic [W:0]   cy;

  assign gen0  = x_i & y_i;
  assign prop0 = x_i ^ y_i;
  assign cy[0] = cin_i;

  generate
    if (PREFIX_CARRY) begin : g_prefix
      logic [W-1:0] gg [0:LVL];
      logic [W-1:0] pp [0:LVL];

      always_comb begin
        gg[0] = gen0;
        pp[0] = prop0;
        for (int k = 0; k < LVL; k++) begin
          for (int i = 0; i < W; i++) begin
            if (i >= (1 << k)) begin
              gg[k+1][i] = gg[k][i] | (pp[k][i] & gg[k][i-(1<<k)]);
              pp[k+1][i] = pp[k][i] & pp[k][i-(1<<k)];
            end else begin
              gg[k+1][i] = gg[k][i];
              pp[k+1][i] = pp[k][i];
            end
          end
        end
      end

      for (genvar i = 0; i < W; i++) begin : g_cy
        assign cy[i+1] = gg[LVL][i] | (pp[LVL][i] & cin_i);
      end
    end else begin : g_ripple
      for (genvar i = 0; i < W; i++) begin : g_fa
        assign cy[i+1] = gen0[i] | (prop0[i] & cy[i]);
      end
    end
  endgenerate

  assign s_o    = prop0 ^ cy[W-1:0];
  assign cout_o = cy[W];
endmodule

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] s_i,
  input  logic         xs_i,
  input  logic         ys_i,
  output logic         z_o,
  output logic         n_o,
  output logic         v_o
);
  assign z_o = (s_i == '0);
  assign n_o = s_i[W-1];
  assign v_o = (xs_i == ys_i) && (s_i[W-1] != xs_i);
endmodule

// File: rtl/cond_adder_alu.sv
module cond_adder_alu
  import cond_alu_pkg::*;
#(
  parameter int WIDTH        = 8,
  parameter bit PREFIX_CARRY = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [4:0]       ctl_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             co_o,
  output logic             zf_o,
  output logic             nf_o,
  output logic             vf_o
);
  localparam int MSB = WIDTH - 1;

  ctl_t             ctl;
  logic [WIDTH-1:0] xa;
  logic [WIDTH-1:0] yb;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_co;
  logic             raw_z;
  logic             raw_n;
  logic             raw_v;

  assign ctl = ctl_t'(ctl_i);

  operand_shaper #(.W(WIDTH)) u_shape_a (
    .d_i  (a_i),
    .clr_i(ctl.clr_a),
    .inv_i(ctl.inv_a),
    .q_o  (xa)
  );

  operand_shaper #(.W(WIDTH)) u_shape_b (
    .d_i  (b_i),
    .clr_i(ctl.clr_b),
    .inv_i(ctl.inv_b),
    .q_o  (yb)
  );

  carry_core #(.W(WIDTH), .PREFIX_CARRY(PREFIX_CARRY)) u_add (
    .x_i   (xa),
    .y_i   (yb),
    .cin_i (ctl.cin),
    .s_o   (raw_sum),
    .cout_o(raw_co)
  );

  flag_unit #(.W(WIDTH)) u_flags (
    .s_i (raw_sum),
    .xs_i(xa[MSB]),
    .ys_i(yb[MSB]),
    .z_o (raw_z),
    .n_o (raw_n),
    .v_o (raw_v)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sum_o <= '0;
      co_o  <= 1'b0;
      zf_o  <= 1'b1;
      nf_o  <= 1'b0;
      vf_o  <= 1'b0;
    end else begin
      sum_o <= raw_sum;
      co_o  <= raw_co;
      zf_o  <= raw_z;
      nf_o  <= raw_n;
      vf_o  <= raw_v;
    end
  end
endmodule

// File: rtl/cond_adder_alu_chk.sv
module cond_adder_alu_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [4:0]   ctl_i,
  input logic [W-1:0] sum_o,
  input logic         co_o,
  input logic         zf_o,
  input logic         nf_o,
  input logic         vf_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (sum_o == '0) && zf_o && !co_o && !nf_o && !vf_o);

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    zf_o == (sum_o == '0));

  // R8
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    nf_o == sum_o[W-1]);

  // R4
  plain_add_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_i == 5'b00000) |=> ({co_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

  // R5
  subtract_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_i == 5'b00011) |=> (sum_o == ($past(a_i) - $past(b_i))) && (co_o == ($past(a_i) >= $past(b_i))));

  // R6
  negate_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_i == 5'b01101) |=> (sum_o == ({W{1'b0}} - $past(a_i))));

  // R9
  add_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctl_i == 5'b00000) |=> (vf_o == (($past(a_i[W-1]) == $past(b_i[W-1])) && (sum_o[W-1] != $past(a_i[W-1])))));
endmodule

bind cond_adder_alu cond_adder_alu_chk #(.W(WIDTH)) u_chk (
  .clk_i(clk_i),
  .rst_i(rst_i),
  .a_i  (a_i),
  .b_i  (b_i),
  .ctl_i(ctl_i),
  .sum_o(sum_o),
  .co_o (co_o),
  .zf_o (zf_o),
  .nf_o (nf_o),
  .vf_o (vf_o)
);

// File: tb/tb_cond_adder_alu.sv
module tb_cond_adder_alu;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic [4:0]   ctl = '0;

  logic [W-1:0] s_p, s_r;
  logic c_p, z_p, n_p, v_p, c_r, z_r, n_r, v_r;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  bit  have_exp = 0;
  bit  exp_rst;
  int  e_s, e_c, e_z, e_n, e_v;
  logic [4:0] e_ctl;

  always #2.5 clk = ~clk;

  cond_adder_alu #(.WIDTH(W), .PREFIX_CARRY(1'b1)) dut (
    .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .ctl_i(ctl),
    .sum_o(s_p), .co_o(c_p), .zf_o(z_p), .nf_o(n_p), .vf_o(v_p)
  );

  cond_adder_alu #(.WIDTH(W), .PREFIX_CARRY(1'b0)) dut_rip (
    .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .ctl_i(ctl),
    .sum_o(s_r), .co_o(c_r), .zf_o(z_r), .nf_o(n_r), .vf_o(v_r)
  );

  function automatic string tag_of(input bit r, input logic [4:0] c);
    if (r) return "R1";
    if (c == 5'b00011) return "R5";
    if (c == 5'b01101 || c == 5'b01100 || c == 5'b10011 || c == 5'b10010) return "R6";
    if ((c[4] && c[3]) || (c[2] && c[1])) return "R3";
    return "R4";
  endfunction

  // behavioural model (R3 conditioning, R4 sum, R7/R8/R9 flags); R2: one-edge latency
  task automatic predict(input bit r, input int av, input int bv, input logic [4:0] c);
    int x, y, t;
    exp_rst = r;
    e_ctl   = c;
    if (r) begin
      e_s = 0; e_c = 0; e_z = 1; e_n = 0; e_v = 0;
    end else begin
      x = c[4] ? 0 : av;
      if (c[3]) x = (~x) & MASK;
      y = c[2] ? 0 : bv;
      if (c[1]) y = (~y) & MASK;
      t   = x + y + int'(c[0]);
      e_s = t & MASK;
      e_c = (t >> W) & 1;
      e_z = (e_s == 0) ? 1 : 0;
      e_n = (e_s >> (W - 1)) & 1;
      e_v = ((((x ^ y) >> (W - 1)) & 1) == 0 && (((e_s ^ x) >> (W - 1)) & 1) == 1) ? 1 : 0;
    end
    have_exp = 1;
  endtask

  task automatic compare_one(input string nm, input logic [W-1:0] s, input logic c,
                             input logic z, input logic n, input logic v, input string ftag);
    string t;
    t = tag_of(exp_rst, e_ctl);
    total++;
    if (int'(s) != e_s || int'(c) != e_c) begin
      bad++;
      $display("FAIL %s %s/%s ctl=%b: sum=%0d co=%0d expected sum=%0d co=%0d",
               ftag, t, nm, e_ctl, s, c, e_s, e_c);
    end else if (int'(z) != e_z) begin
      bad++;
      $display("FAIL %s R7 %s: zf=%0d expected %0d", ftag, nm, z, e_z);
    end else if (int'(n) != e_n) begin
      bad++;
      $display("FAIL %s R8 %s: nf=%0d expected %0d", ftag, nm, n, e_n);
    end else if (int'(v) != e_v) begin
      bad++;
      $display("FAIL %s R9 %s ctl=%b: vf=%0d expected %0d", ftag, nm, e_ctl, v, e_v);
    end
  endtask

  // drive at the falling edge: first check what the last rising edge produced
  task automatic step(input bit r, input int av, input int bv, input logic [4:0] c);
    @(negedge clk);
    if (have_exp) begin
      compare_one("prefix", s_p, c_p, z_p, n_p, v_p, "R2");
      compare_one("ripple", s_r, c_r, z_r, n_r, v_r, "R10");
    end
    rst = r;
    a   = W'(av);
    b   = W'(bv);
    ctl = c;
    predict(r, av, bv, c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=%0d expected below 50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(1'b1, 0, 0, 5'b00000);           // R1 reset state
    step(1'b1, 0, 0, 5'b00000);
    for (int c = 0; c < 32; c++) begin
      for (int av = 0; av <= MASK; av++) begin
        for (int bv = 0; bv <= MASK; bv++) begin
          step(1'b0, av, bv, 5'(c));      // R3..R10 full sweep
        end
      end
    end
    step(1'b1, 9, 7, 5'b11110);           // R1 reset mid-run with busy inputs
    step(1'b0, MASK, MASK, 5'b11110);     // R3 clear+invert on both operands
    step(1'b0, 0, 0, 5'b00000);
    step(1'b0, 0, 0, 5'b00000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule